// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a parameterized set of maskable peripheral interrupt sources and eight non-maskable trap sources into a single request line for a processor core. Each request event is captured in a per-source pending flag. A two-tier arbiter picks one winner from all pending flags. The first tier compares priority levels. The second tier picks the lowest vector position among equal levels. The block registers the winner and offers it to the core as a vector index, an effective level and the program-memory address of its vector-table entry.

Maskable sources carry an enable bit and a 3-bit priority. Such a source competes only when its priority is above the core's current level. Traps always compete and outrank every maskable level. A single table-select input moves every entry address into a second table of the same layout. The offer is held until the core acknowledges it. The acknowledge retires the accepted source's pending flag, and arbitration resumes on the next cycle.

The controller has two states, named below with their transitions:
- ST_IDLE: no offer is outstanding. The transition ARBITRATE goes to ST_OFFER when any candidate qualifies. STAY_IDLE keeps ST_IDLE otherwise.
- ST_OFFER: a winner is presented. The transition RETIRE goes back to ST_IDLE on acknowledge. WAIT_ACK keeps ST_OFFER otherwise.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A maskable source can win only when it is pending, its enable bit is 1, its priority is nonzero, and its priority is strictly greater than `cpu_level`. A priority of 0 never requests.
- R2: Among qualifying maskable sources, the highest priority wins.
- R3: Among qualifying maskable sources of equal priority, the lowest source number wins.
- R4: Any pending trap beats every maskable source. Traps ignore enable bits and `cpu_level`. Among traps, the lowest trap number wins. Trap t reports level 15 − t.
- R5: Trap t reports index t. Maskable source i reports index 8 + i, and a maskable winner reports its own priority as its level.
- R6: With `alt_table` = 0, `vec_addr` = 0x000004 + 2 × index. With `alt_table` = 1, `vec_addr` = 0x000104 + 2 × index. `alt_table` is sampled when the winner is registered.
- R7: Fixed latency when idle. A raise pulse sampled at clock edge k sets the pending flag. `irq_req` rises after edge k+1, whatever source wins.
- R8: While `irq_req` is high and `irq_ack` is low, `irq_req`, `vec_index`, `vec_level` and `vec_addr` stay unchanged, even if higher-ranked sources arrive.
- R9: `irq_ack` sampled high while `irq_req` is high clears the accepted source's pending flag and drops `irq_req` for one cycle. Arbitration resumes at the following edge.
- R10: When nothing qualifies, `irq_req` stays low and `vec_index`, `vec_level` and `vec_addr` keep their previous values.
- R11: If a raise for a source arrives in the same cycle as the acknowledge that clears it, the flag stays set.
- R12: After reset, `irq_req` = 0, `vec_index` = 0, `vec_level` = 0, `vec_addr` = 0, and all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_raise | input | NUM_SRC | One-cycle pulses that set maskable pending flags |
| src_enable | input | NUM_SRC | Per-source enable |
| src_prio | input | NUM_SRC*3 | Per-source priority; source i uses bits [3i+2:3i] |
| trap_raise | input | 8 | One-cycle pulses that set trap pending flags |
| cpu_level | input | 3 | Current priority level of the core |
| alt_table | input | 1 | Selects the second vector table |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_req | output | 1 | Request to the core |
| vec_index | output | IDX_W | Vector-table position of the winner |
| vec_level | output | 4 | Effective level of the winner |
| vec_addr | output | 24 | Address of the winner's table entry |

## Verification
A stuck or wrong state register shows at the ports within one cycle. Either `irq_req` fails to drop right after an acknowledge, or it rises one edge early or late compared with the fixed two-edge latency. A pending flag that is not cleared, or is cleared for the wrong source, shows as a repeated or missing offer two edges after the acknowledge. A fault in the arbiter ordering or in the address arithmetic is caught on the first offer that follows a mixed set of raises. Each such offer is compared against the index, level and address computed independently for that pattern.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int PRIO_W    = 3;
    localparam int LVL_W     = 4;
    localparam int NUM_TRAP  = 8;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } vic_state_e;

endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
        logic flag_q;
        // a new event in the same cycle as its clear is kept
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= set_i[g] | (flag_q & ~clr_i[g]);
            end
        end
        assign pend_o[g] = flag_q;
    end

endmodule

// File: rtl/vic_select.sv
module vic_select
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0]        src_pend_i,
    input  logic [NUM_SRC-1:0]        src_en_i,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
    input  logic [NUM_TRAP-1:0]       trap_pend_i,
    input  logic [PRIO_W-1:0]         cpu_level_i,
    output logic                      cand_valid_o,
    output logic [IDX_W-1:0]          cand_idx_o,
    output logic [LVL_W-1:0]          cand_lvl_o
);

    localparam int SRC_IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int TRP_IW = $clog2(NUM_TRAP);

    logic [PRIO_W-1:0] best_lvl;
    logic [SRC_IW-1:0] best_src;
    logic              trap_hit;
    logic [TRP_IW-1:0] trap_sel;

    // maskable tier: scan downward so the lowest index wins ties
    always_comb begin
        best_lvl = '0;
        best_src = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            logic [PRIO_W-1:0] p;
            p = src_prio_i[i*PRIO_W +: PRIO_W];
            if (src_pend_i[i] && src_en_i[i] && (p > cpu_level_i) && (p >= best_lvl)) begin
                best_lvl = p;
                best_src = SRC_IW'(i);
            end
        end
    end

    // trap tier: unmaskable, lowest index wins
    always_comb begin
        trap_hit = 1'b0;
        trap_sel = '0;
        for (int t = NUM_TRAP - 1; t >= 0; t--) begin
            if (trap_pend_i[t]) begin
                trap_hit = 1'b1;
                trap_sel = TRP_IW'(t);
            end
        end
    end

    always_comb begin
        cand_valid_o = trap_hit || (best_lvl != '0);
        if (trap_hit) begin
            cand_idx_o = IDX_W'(trap_sel);
            cand_lvl_o = LVL_W'((2**LVL_W - 1) - int'(trap_sel));
        end else begin
            cand_idx_o = IDX_W'(NUM_TRAP) + IDX_W'(best_src);
            cand_lvl_o = LVL_W'(best_lvl);
        end
    end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import vic_pkg::*;
#(
    parameter int          NUM_SRC  = 16,
    parameter int          ADDR_W   = 24,
    parameter logic [23:0] PRI_BASE = 24'h000004,
    parameter logic [23:0] ALT_BASE = 24'h000104,
    localparam int         IDX_W    = $clog2(NUM_TRAP + NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_raise,
    input  logic [NUM_SRC-1:0]        src_enable,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_TRAP-1:0]       trap_raise,
    input  logic [PRIO_W-1:0]         cpu_level,
    input  logic                      alt_table,
    input  logic                      irq_ack,
    output logic                      irq_req,
    output logic [IDX_W-1:0]          vec_index,
    output logic [LVL_W-1:0]          vec_level,
    output logic [ADDR_W-1:0]         vec_addr
);

    vic_state_e          state_q, state_d;
    logic [NUM_SRC-1:0]  src_pend, src_clr;
    logic [NUM_TRAP-1:0] trap_pend, trap_clr;
    logic                cand_valid;
    logic [IDX_W-1:0]    cand_idx;
    logic [LVL_W-1:0]    cand_lvl;
    logic [IDX_W-1:0]    win_idx_q;
    logic [LVL_W-1:0]    win_lvl_q;
    logic [ADDR_W-1:0]   win_addr_q;
    logic                retire;
    logic                capture;

    vic_pending #(.WIDTH(NUM_SRC)) u_src_pend (
        .clk(clk), .rst_n(rst_n), .set_i(src_raise), .clr_i(src_clr), .pend_o(src_pend)
    );

    vic_pending #(.WIDTH(NUM_TRAP)) u_trap_pend (
        .clk(clk), .rst_n(rst_n), .set_i(trap_raise), .clr_i(trap_clr), .pend_o(trap_pend)
    );

    vic_select #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_select (
        .src_pend_i  (src_pend),
        .src_en_i    (src_enable),
        .src_prio_i  (src_prio),
        .trap_pend_i (trap_pend),
        .cpu_level_i (cpu_level),
        .cand_valid_o(cand_valid),
        .cand_idx_o  (cand_idx),
        .cand_lvl_o  (cand_lvl)
    );

    assign retire  = (state_q == ST_OFFER) && irq_ack;
    assign capture = (state_q == ST_IDLE) && cand_valid;

    // clear vector decoded from the registered winner
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_clr
        assign src_clr[g] = retire && (win_idx_q == IDX_W'(NUM_TRAP + g));
    end
    for (genvar g = 0; g < NUM_TRAP; g++) begin : g_trap_clr
        assign trap_clr[g] = retire && (win_idx_q == IDX_W'(g));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ARBITRATE / STAY_IDLE / RETIRE / WAIT_ACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cand_valid) state_d = ST_OFFER;
            ST_OFFER: if (irq_ack)    state_d = ST_IDLE;
        endcase
    end

    // winner registers, loaded only on ARBITRATE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_idx_q  <= '0;
            win_lvl_q  <= '0;
            win_addr_q <= '0;
        end else if (capture) begin
            win_idx_q  <= cand_idx;
            win_lvl_q  <= cand_lvl;
            win_addr_q <= (alt_table ? ADDR_W'(ALT_BASE) : ADDR_W'(PRI_BASE))
                          + (ADDR_W'(cand_idx) << 1);
        end
    end

    // outputs
    always_comb begin
        irq_req   = (state_q == ST_OFFER);
        vec_index = win_idx_q;
        vec_level = win_lvl_q;
        vec_addr  = win_addr_q;
    end

    // ---------------- assertions ----------------
    logic cand_src_ok;
    always_comb begin
        cand_src_ok = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand_idx == IDX_W'(NUM_TRAP + i)) cand_src_ok = src_pend[i] & src_enable[i];
        end
    end

    // R1: a maskable candidate is always a pending, enabled source
    p_cand_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_idx >= IDX_W'(NUM_TRAP)) |-> cand_src_ok);

    // R4: a pending trap always takes the candidate slot
    p_trap_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|trap_pend) |-> (cand_valid && cand_idx < IDX_W'(NUM_TRAP)));

    // R8: offer held until acknowledged
    p_offer_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(vec_index) && $stable(vec_addr) && $stable(vec_level)));

    // R9: request drops right after an acknowledge
    p_drop_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    // R10: with nothing qualifying, outputs hold
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !cand_valid) |=> (!irq_req && $stable(vec_index) && $stable(vec_addr)));

endmodule

// File: tb/irq_vector_arbiter_bench.sv
module irq_vector_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 16;
    localparam int IW   = $clog2(8 + N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    src_raise = '0;
    logic [N-1:0]    src_enable = '0;
    logic [N*3-1:0]  src_prio = '0;
    logic [7:0]      trap_raise = '0;
    logic [2:0]      cpu_level = '0;
    logic            alt_table = 1'b0;
    logic            irq_ack = 1'b0;
    logic            irq_req;
    logic [IW-1:0]   vec_index;
    logic [3:0]      vec_level;
    logic [23:0]     vec_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_arbiter #(.NUM_SRC(N)) u_irq_vector_arbiter (
        .clk(clk), .rst_n(rst_n), .src_raise(src_raise), .src_enable(src_enable),
        .src_prio(src_prio), .trap_raise(trap_raise), .cpu_level(cpu_level),
        .alt_table(alt_table), .irq_ack(irq_ack), .irq_req(irq_req),
        .vec_index(vec_index), .vec_level(vec_level), .vec_addr(vec_addr)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_offer(string req, int idx, int lvl, int addr);
        chk(req, "irq_req", int'(irq_req), 1);
        chk(req, "vec_index", int'(vec_index), idx);
        chk(req, "vec_level", int'(vec_level), lvl);
        chk(req, "vec_addr", int'(vec_addr), addr);
    endtask

    task automatic set_src(int i, bit en, int p);
        src_enable[i] = en;
        src_prio[i*3 +: 3] = 3'(p);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        src_raise = '0; src_enable = '0; src_prio = '0; trap_raise = '0;
        cpu_level = '0; alt_table = 1'b0; irq_ack = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic raise(logic [N-1:0] m, logic [7:0] t);
        src_raise = m; trap_raise = t;
        tick();
        src_raise = '0; trap_raise = '0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12", "irq_req", int'(irq_req), 0);
        chk("R12", "vec_index", int'(vec_index), 0);
        chk("R12", "vec_level", int'(vec_level), 0);
        chk("R12", "vec_addr", int'(vec_addr), 0);
        tick();
        chk("R12", "irq_req idle", int'(irq_req), 0);
    endtask

    task automatic t_qualify();
        do_reset();
        set_src(3, 1, 2); set_src(4, 0, 7); set_src(6, 1, 0);
        cpu_level = 3'd2;
        raise(16'h0058, 8'h00);
        tick(); tick();
        chk("R1", "not above cpu_level / disabled / prio0", int'(irq_req), 0);
        cpu_level = 3'd1;
        tick();
        chk_offer("R1", 8 + 3, 2, 4 + 2 * 11);
    endtask

    task automatic t_priority();
        do_reset();
        set_src(2, 1, 3); set_src(5, 1, 6);
        raise(16'h0024, 8'h00);
        chk("R7", "one edge after raise", int'(irq_req), 0);
        tick();
        chk_offer("R2", 13, 6, 4 + 26);
    endtask

    task automatic t_tie_and_ack();
        do_reset();
        set_src(4, 1, 5); set_src(1, 1, 5);
        raise(16'h0012, 8'h00);
        tick();
        chk_offer("R3", 9, 5, 4 + 18);
        ack_once();
        chk("R9", "req low after ack", int'(irq_req), 0);
        tick();
        chk_offer("R9", 12, 5, 4 + 24);
        ack_once();
        tick(); tick();
        chk("R10", "req low nothing pending", int'(irq_req), 0);
        chk("R10", "index held", int'(vec_index), 12);
        chk("R10", "addr held", int'(vec_addr), 4 + 24);
    endtask

    task automatic t_traps();
        do_reset();
        set_src(0, 0, 7);
        cpu_level = 3'd7;
        src_enable[1] = 1'b1; src_prio[5:3] = 3'd7;
        raise(16'h0003, 8'h24);
        tick();
        chk_offer("R4", 2, 13, 4 + 4);
        ack_once(); tick();
        chk_offer("R4", 5, 10, 4 + 10);
        ack_once(); tick();
        chk("R4", "masked maskable after traps", int'(irq_req), 0);
    endtask

    task automatic t_alt_and_last();
        do_reset();
        alt_table = 1'b1;
        set_src(0, 1, 1);
        raise(16'h0001, 8'h00);
        tick();
        chk_offer("R6", 8, 1, 24'h104 + 16);
        ack_once();
        alt_table = 1'b0;
        set_src(N - 1, 1, 4);
        raise(16'h8000, 8'h00);
        tick();
        chk_offer("R5", 8 + N - 1, 4, 4 + 2 * (8 + N - 1));
    endtask

    task automatic t_hold();
        do_reset();
        set_src(7, 1, 2); set_src(8, 1, 7);
        raise(16'h0080, 8'h00);
        tick();
        chk_offer("R8", 15, 2, 4 + 30);
        raise(16'h0100, 8'h01);
        tick(); tick();
        chk_offer("R8", 15, 2, 4 + 30);
        ack_once(); tick();
        chk_offer("R8", 0, 15, 4);
    endtask

    task automatic t_raise_on_ack();
        do_reset();
        set_src(10, 1, 3);
        raise(16'h0400, 8'h00);
        tick();
        chk_offer("R11", 18, 3, 4 + 36);
        src_raise = 16'h0400; irq_ack = 1'b1;
        tick();
        src_raise = '0; irq_ack = 1'b0;
        chk("R11", "req low after ack", int'(irq_req), 0);
        tick();
        chk_offer("R11", 18, 3, 4 + 36);
    endtask

    initial begin
        t_reset();
        t_qualify();
        t_priority();
        t_tie_and_ack();
        t_traps();
        t_alt_and_last();
        t_hold();
        t_raise_on_ack();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule